// File: doc/BRIEF.md
# Packed Integer Multiply Unit

This block multiplies two 64-bit operands in one of three ways, chosen per operation by a 2-bit mode input. In the two word modes each operand is split into four signed 16-bit lanes. Every lane is multiplied only by the matching lane of the other operand, and each result lane takes either the upper or the lower 16 bits of its 32-bit signed product. In the doubleword mode the low 32 bits of each operand are read as unsigned numbers, and the full 64-bit product is returned.

An operation is accepted on any cycle in which `valid_i` is high, so a new one may issue every cycle. Its result appears with `valid_o` exactly two cycles later. The fourth mode code is reserved. It returns zero and raises `illegal_o`. The unit produces no condition flags. Lane width and lane count are parameters, and the doubleword width is half of the operand width.

Top module: `pmul_unit`

## Requirements
- R1: With mode 2'b00, result lane i (bits 16i+15:16i, i = 0..3) holds bits 31:16 of the signed 32-bit product of operand lanes i.
- R2: With mode 2'b01, result lane i holds bits 15:0 of the signed 32-bit product of operand lanes i.
- R3: Lanes occupy bits 15:0, 31:16, 47:32 and 63:48. Each result lane depends only on the same lane of both operands.
- R4: With mode 2'b10, the result is the unsigned 64-bit product of bits 31:0 of both operands. Bits 63:32 of the operands have no effect.
- R5: With mode 2'b11, the result is zero and `illegal_o` is high with `valid_o`. For every other mode `illegal_o` is low.
- R6: An operation accepted in cycle n gives `valid_o` high for exactly one cycle, in cycle n+2. Operations issued every cycle each produce a result, in issue order.
- R7: For -32768 times -32768 in a lane, the lane result is 0x4000 in mode 2'b00 and 0x0000 in mode 2'b01.
- R8: While `rst_ni` is low, `valid_o` and `illegal_o` are low. An operation that is in flight when reset asserts never produces `valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe for the operation on the inputs |
| mode_i | input | 2 | 00 signed high word, 01 signed low word, 10 unsigned doubleword, 11 reserved |
| src_a_i | input | 64 | First operand |
| src_b_i | input | 64 | Second operand |
| valid_o | output | 1 | Result valid, two cycles after issue |
| illegal_o | output | 1 | Reserved mode was issued (qualified by valid_o) |
| result_o | output | 64 | Packed result |

## Verification
The bench builds the unit with its default 16-bit lanes and four lanes, which is the configuration every requirement is stated in. Each lane is fed from a 16-entry set of corner values that includes zero, ±1, both signed extremes and alternating bit patterns. Every pairing is swept through all four modes, with different pairings in the other lanes. This reaches the sign-boundary products, the minimum-times-minimum corner, and lane crosstalk. The doubleword mode is driven with noisy upper halves, so any leak from those bits shows in the result. Issue streams run back to back and with gaps, and a reset lands on an operation in flight, which covers the latency and the flush behaviour.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [1:0] {
    MODE_MUL_HI = 2'b00,
    MODE_MUL_LO = 2'b01,
    MODE_MUL_DW = 2'b10,
    MODE_RSVD   = 2'b11
  } pmul_mode_e;
endpackage

// File: rtl/pmul_lane.sv
// One signed lane: full product, split into halves.
module pmul_lane #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  logic signed [2*W-1:0] a_x, b_x, prod;

  assign a_x  = {{W{a_i[W-1]}}, a_i};
  assign b_x  = {{W{b_i[W-1]}}, b_i};
  assign prod = a_x * b_x;
  assign hi_o = prod[2*W-1:W];
  assign lo_o = prod[W-1:0];
endmodule

// File: rtl/pmul_dword.sv
// Unsigned W x W -> 2W multiply.
module pmul_dword #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  logic [2*W-1:0] a_x, b_x;

  assign a_x    = {{W{1'b0}}, a_i};
  assign b_x    = {{W{1'b0}}, b_i};
  assign prod_o = a_x * b_x;
endmodule

// File: rtl/pmul_select.sv
module pmul_select
  import pmul_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  pmul_mode_e        mode_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] dw_i,
  output logic [DATA_W-1:0] result_o,
  output logic              illegal_o
);
  always_comb begin
    illegal_o = 1'b0;
    unique case (mode_i)
      MODE_MUL_HI: result_o = hi_i;
      MODE_MUL_LO: result_o = lo_i;
      MODE_MUL_DW: result_o = dw_i;
      default: begin
        result_o  = '0;
        illegal_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned NUM_LANES = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic [1:0]                  mode_i,
  input  logic [LANE_W*NUM_LANES-1:0] src_a_i,
  input  logic [LANE_W*NUM_LANES-1:0] src_b_i,
  output logic                        valid_o,
  output logic                        illegal_o,
  output logic [LANE_W*NUM_LANES-1:0] result_o
);
  localparam int unsigned DATA_W = LANE_W * NUM_LANES;
  localparam int unsigned DW_W   = DATA_W / 2;
  localparam logic [LANE_W-1:0] LANE_MIN     = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] MIN_SQ_HIGH  = {2'b01, {(LANE_W-2){1'b0}}};

  // stage 1: operand capture
  logic              s1_valid_q;
  pmul_mode_e        s1_mode_q;
  logic [DATA_W-1:0] s1_a_q, s1_b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_mode_q  <= MODE_MUL_HI;
      s1_a_q     <= '0;
      s1_b_q     <= '0;
    end else begin
      s1_valid_q <= valid_i;
      if (valid_i) begin
        s1_mode_q <= pmul_mode_e'(mode_i);
        s1_a_q    <= src_a_i;
        s1_b_q    <= src_b_i;
      end
    end
  end

  // multiply datapath
  logic [DATA_W-1:0] hi_vec, lo_vec, dw_prod, sel_result;
  logic              sel_illegal;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    pmul_lane #(.W(LANE_W)) i_lane (
      .a_i  (s1_a_q[g*LANE_W +: LANE_W]),
      .b_i  (s1_b_q[g*LANE_W +: LANE_W]),
      .hi_o (hi_vec[g*LANE_W +: LANE_W]),
      .lo_o (lo_vec[g*LANE_W +: LANE_W])
    );
  end

  pmul_dword #(.W(DW_W)) i_dword (
    .a_i    (s1_a_q[DW_W-1:0]),
    .b_i    (s1_b_q[DW_W-1:0]),
    .prod_o (dw_prod)
  );

  pmul_select #(.DATA_W(DATA_W)) i_select (
    .mode_i    (s1_mode_q),
    .hi_i      (hi_vec),
    .lo_i      (lo_vec),
    .dw_i      (dw_prod),
    .result_o  (sel_result),
    .illegal_o (sel_illegal)
  );

  // stage 2: result register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o   <= s1_valid_q;
      illegal_o <= s1_valid_q & sel_illegal;
      if (s1_valid_q) result_o <= sel_result;
    end
  end

  AST_ISSUE_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> s1_valid_q); // R6
  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_q |=> valid_o); // R6
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid_q |=> !valid_o); // R6
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (valid_o && result_o == '0)); // R5
  AST_RSVD_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && s1_mode_q == MODE_RSVD) |=> illegal_o); // R5
  AST_LEGAL_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && s1_mode_q != MODE_RSVD) |=> !illegal_o); // R5
  AST_MIN_SQUARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && s1_mode_q == MODE_MUL_HI && s1_a_q[LANE_W-1:0] == LANE_MIN
     && s1_b_q[LANE_W-1:0] == LANE_MIN) |=> result_o[LANE_W-1:0] == MIN_SQ_HIGH); // R7
  AST_DW_ZERO_OPERAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_valid_q && s1_mode_q == MODE_MUL_DW && s1_a_q[DW_W-1:0] == '0)
    |=> result_o == '0); // R4
endmodule

// File: tb/test_pmul_unit.sv
`timescale 1ns/1ps
module test_pmul_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [63:0] src_a_i = '0, src_b_i = '0;
  logic        valid_o, illegal_o;
  logic [63:0] result_o;

  always #4 clk = ~clk;

  pmul_unit i_pmul_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .mode_i(mode_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i),
    .valid_o(valid_o), .illegal_o(illegal_o), .result_o(result_o)
  );

  int n_chk = 0, n_fail = 0;
  bit mon_en = 1'b0;
  logic [63:0] exp_q[$];
  logic        ill_q[$];
  string       tag_q[$];

  function automatic logic [15:0] val(input int k);
    case (k & 15)
      0: val = 16'h0000;  1: val = 16'h0001;  2: val = 16'hFFFF;  3: val = 16'h0002;
      4: val = 16'hFFFE;  5: val = 16'h7FFF;  6: val = 16'h8000;  7: val = 16'h8001;
      8: val = 16'h00FF;  9: val = 16'h0100; 10: val = 16'h1234; 11: val = 16'hEDCB;
     12: val = 16'h4000; 13: val = 16'hC000; 14: val = 16'h5555; default: val = 16'hAAAA;
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [1:0] m);
    logic [63:0] r = '0;
    if (m == 2'b00 || m == 2'b01) begin
      for (int i = 0; i < 4; i++) begin
        logic signed [15:0] x, y;
        logic signed [31:0] p;
        x = a[16*i +: 16];
        y = b[16*i +: 16];
        p = x * y;
        r[16*i +: 16] = (m == 2'b00) ? p[31:16] : p[15:0];
      end
    end else if (m == 2'b10) begin
      r = {32'b0, a[31:0]} * {32'b0, b[31:0]};
    end
    return r;
  endfunction

  function automatic string mtag(input logic [1:0] m);
    case (m)
      2'b00: mtag = "R1/R3";
      2'b01: mtag = "R2/R3";
      2'b10: mtag = "R4";
      default: mtag = "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] m, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    valid_i = 1'b1; mode_i = m; src_a_i = a; src_b_i = b;
    exp_q.push_back(model(a, b, m));
    ill_q.push_back(m == 2'b11);
    tag_q.push_back(mtag(m));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // result monitor
  always @(negedge clk) begin
    if (mon_en && valid_o) begin
      if (exp_q.size() == 0) begin
        check("R6 unexpected valid_o", 64'd1, 64'd0);
      end else begin
        logic [63:0] e;
        logic        il;
        string       t;
        e = exp_q.pop_front(); il = ill_q.pop_front(); t = tag_q.pop_front();
        check(t, result_o, e);
        check({t, " R5 illegal_o"}, {63'b0, illegal_o}, {63'b0, il});
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL R6 watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R8: outputs idle in reset
    repeat (3) @(negedge clk);
    check("R8 valid_o in reset", {63'b0, valid_o}, 64'd0);
    check("R8 illegal_o in reset", {63'b0, illegal_o}, 64'd0);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    idle(2);

    // R6: exact latency, single pulse
    issue(2'b00, 64'h0003_0003_0003_0003, 64'h0005_0005_0005_0005);
    @(negedge clk); valid_i = 1'b0;
    check("R6 no result after one cycle", {63'b0, valid_o}, 64'd0);
    @(negedge clk);
    check("R6 result after two cycles", {63'b0, valid_o}, 64'd1);
    @(negedge clk);
    check("R6 valid_o single pulse", {63'b0, valid_o}, 64'd0);

    // R7: minimum times minimum, checked against constants
    issue(2'b00, {4{16'h8000}}, {4{16'h8000}});
    idle(1);
    @(negedge clk);
    check("R7 high min*min", result_o, {4{16'h4000}});
    issue(2'b01, {4{16'h8000}}, {4{16'h8000}});
    idle(1);
    @(negedge clk);
    check("R7 low min*min", result_o, 64'd0);
    idle(1);

    // R1 R2 R3 R5: back-to-back sweep over lane corner values, every mode
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        for (int m = 0; m < 4; m++) begin
          logic [63:0] a, b;
          a = {val(i ^ j), val(i + j), val(j), val(i)};
          b = {val(15 - i), val(i + 3 * j), val(i), val(j)};
          if (m == 2) begin
            // R4: noise in upper halves must not matter
            a[63:32] = {val(i * 7), val(j * 5)};
            b[63:32] = {val(j * 3), val(i + 9)};
          end
          issue(2'(m), a, b);
        end
      end
    end
    idle(3);

    // R4: doubleword extremes with gaps between issues
    issue(2'b10, 64'hDEAD_BEEF_FFFF_FFFF, 64'h1234_5678_FFFF_FFFF); idle(1);
    issue(2'b10, 64'hFFFF_FFFF_0000_0001, 64'hFFFF_FFFF_8000_0000); idle(2);
    issue(2'b10, 64'hFFFF_FFFF_0000_0000, 64'h0123_4567_89AB_CDEF); idle(1);
    issue(2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF); idle(3);
    check("R6 all issued operations returned", 64'(exp_q.size()), 64'd0);

    // R8: reset drops an operation in flight
    issue(2'b01, 64'h0007_0007_0007_0007, 64'h0009_0009_0009_0009);
    @(negedge clk); valid_i = 1'b0; rst_ni = 1'b0;
    @(negedge clk);
    check("R8 valid_o after mid-run reset", {63'b0, valid_o}, 64'd0);
    @(negedge clk);
    check("R8 flushed op never valid", {63'b0, valid_o}, 64'd0);
    exp_q.delete(); ill_q.delete(); tag_q.delete();
    rst_ni = 1'b1;
    idle(3);
    check("R8 no late result after reset", {63'b0, valid_o}, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule